// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one data word into an asynchronous serial frame on a single output line. The word has up to nine bits and arrives over a valid/ready handshake. The frame shape comes from a set of packed control fields:

- a two-bit word-length code;
- a parity enable bit and a parity sense bit;
- a two-bit stop-length code.

An external baud generator supplies a one-cycle tick for every bit period. The block advances the line by exactly one frame bit on each tick.

The control fields are decoded continuously, so any change to them is seen at once. The decoded format is captured when a word is accepted. Later changes to the fields do not affect the frame being sent. A field combination the block cannot produce raises a configuration-error flag. While that flag is high, the block refuses new words and keeps the line idle.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line output is high, busy is low, and the ready output is high while the control fields are legal.
- R2: A frame starts with one low start bit. That bit appears on the first tick after acceptance. Each frame bit holds the line from one tick until the next, unchanged between ticks.
- R3: Data bits follow the start bit, least significant first. The word-length code {len_hi, len_lo} selects the number of data bits: 00 gives 8, 01 gives 9 and 10 gives 7. Word bits above the selected length are not sent.
- R4: When par_en is 0, no parity bit is inserted and the stop bits follow the last data bit directly.
- R5: When par_en is 1, one parity bit follows the data bits. It is computed over the selected data bits only. With par_odd 0 the total number of ones (data plus parity) is even; with par_odd 1 it is odd.
- R6: Stop-length code 00 sends one high stop bit and code 10 sends two. After the last stop bit, one more tick returns the block to idle with the line high.
- R7: Word-length code 11 drives cfg_err high and ready low. A valid word offered in that state is not accepted, busy stays low and the line stays high.
- R8: Stop-length codes 01 and 11 (fractional stop lengths) drive cfg_err high and ready low. A valid word offered in that state is not accepted and the line stays high.
- R9: Ready is high only when the block is idle and the fields are legal. Busy rises the cycle after a word is accepted and stays high until the end-of-frame tick.
- R10: The frame format is captured at acceptance. Field changes during a frame, illegal ones included, do not alter the frame in flight, but cfg_err follows the current fields at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_i | input | 9 | Data word to send |
| word_valid_i | input | 1 | Word offered |
| word_ready_o | output | 1 | Word taken when high together with valid |
| len_hi_i | input | 1 | Word-length code, high bit |
| len_lo_i | input | 1 | Word-length code, low bit |
| par_en_i | input | 1 | Insert a parity bit |
| par_odd_i | input | 1 | Odd parity when set, even when clear |
| stop_code_i | input | 2 | Stop-length code |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| tx_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | Frame in progress |
| cfg_err_o | output | 1 | Current fields are illegal |

## Verification
The assertions assume that reset is held low across the first clock edge. They also assume that bit_tick_i is a single-cycle pulse, so the line may change only on a tick. The bench therefore raises the tick for exactly one cycle at a time, sometimes with idle cycles between ticks. It changes the control fields only at the falling edge, either between frames or at one chosen point inside a frame, so each decode is settled before the next rising edge samples it.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int MAX_W = 9,
  localparam int FW = MAX_W + 4,
  localparam int CW = $clog2(FW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAX_W-1:0] word_i,
  input  logic             word_valid_i,
  output logic             word_ready_o,
  input  logic             len_hi_i,
  input  logic             len_lo_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  input  logic [1:0]       stop_code_i,
  input  logic             bit_tick_i,
  output logic             tx_o,
  output logic             busy_o,
  output logic             cfg_err_o
);

  logic [CW-1:0] len, nbits, cnt_q;
  logic [FW-1:0] frame, sh_q;
  logic          pbit, busy_q, tx_q, accept;

  always_comb begin
    case ({len_hi_i, len_lo_i})
      2'b00:   len = CW'(8);
      2'b01:   len = CW'(9);
      2'b10:   len = CW'(7);
      default: len = '0;
    endcase
  end

  assign cfg_err_o    = (len_hi_i & len_lo_i) | stop_code_i[0];
  assign word_ready_o = !busy_q && !cfg_err_o;
  assign accept       = word_valid_i && word_ready_o;

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    pbit     = par_odd_i;
    for (int i = 0; i < MAX_W; i++) begin
      if (i < int'(len)) begin
        frame[1+i] = word_i[i];
        pbit       = pbit ^ word_i[i];
      end
    end
    if (par_en_i) frame[1+int'(len)] = pbit;
    nbits = CW'(2 + int'(len) + int'(par_en_i) + int'(stop_code_i[1]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      tx_q   <= 1'b1;
    end else if (accept) begin
      sh_q   <= frame;
      cnt_q  <= nbits;
      busy_q <= 1'b1;
    end else if (busy_q && bit_tick_i) begin
      if (cnt_q != '0) begin
        tx_q  <= sh_q[0];
        sh_q  <= {1'b1, sh_q[FW-1:1]};
        cnt_q <= cnt_q - 1'b1;
      end else begin
        tx_q   <= 1'b1;
        busy_q <= 1'b0;
      end
    end
  end

  assign tx_o   = tx_q;
  assign busy_o = busy_q;

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> tx_o);
  a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_i && word_ready_o) |=> busy_o);
  a_r7_err_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err_o && !busy_o) |=> !busy_o);
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !bit_tick_i) |=> ($stable(tx_o) && busy_o));
  a_r6_end_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> tx_o);

endmodule

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] word_i = '0;
  logic       word_valid_i = 1'b0;
  logic       len_hi_i = 1'b0, len_lo_i = 1'b0, par_en_i = 1'b0, par_odd_i = 1'b0;
  logic [1:0] stop_code_i = 2'b00;
  logic       bit_tick_i = 1'b0;
  logic       word_ready_o, tx_o, busy_o, cfg_err_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_frame_tx i_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .word_valid_i(word_valid_i),
    .word_ready_o(word_ready_o), .len_hi_i(len_hi_i), .len_lo_i(len_lo_i),
    .par_en_i(par_en_i), .par_odd_i(par_odd_i), .stop_code_i(stop_code_i),
    .bit_tick_i(bit_tick_i), .tx_o(tx_o), .busy_o(busy_o), .cfg_err_o(cfg_err_o));

  // {len_hi, len_lo, par_en, par_odd, stop[1:0], data[8:0]}
  localparam logic [14:0] VEC [0:7] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 9'h0A5},
    {1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 9'h1C3},
    {1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 9'h1D5},
    {1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 9'h0FF},
    {1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 9'h100},
    {1'b1, 1'b0, 1'b1, 1'b0, 2'b10, 9'h07F},
    {1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 9'h000},
    {1'b0, 1'b1, 1'b1, 1'b1, 2'b10, 9'h1FF}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [14:0] v, input bit midchg);
    logic [12:0] exp_bits;
    string       tag [0:12];
    int          len, n, ones;
    bit          p;
    len = v[14] ? 7 : (v[13] ? 9 : 8);
    exp_bits = '1;
    exp_bits[0] = 1'b0;
    tag[0] = "R2 start";
    ones = 0;
    for (int i = 0; i < len; i++) begin
      exp_bits[1+i] = v[i];
      tag[1+i] = "R3 data";
      ones += int'(v[i]);
    end
    n = 1 + len;
    if (v[12]) begin
      p = v[11] ? ((ones % 2) == 0) : ((ones % 2) == 1);
      exp_bits[n] = p;
      tag[n] = "R5 parity";
      n++;
    end
    for (int s = 0; s < (v[10] ? 2 : 1); s++) begin
      tag[n] = v[12] ? "R6 stop" : "R4/R6 stop after data";
      n++;
    end
    @(negedge clk);
    {len_hi_i, len_lo_i, par_en_i, par_odd_i, stop_code_i} = v[14:9];
    word_i = v[8:0];
    word_valid_i = 1'b1;
    #0.5;
    chk(word_ready_o == 1'b1 && cfg_err_o == 1'b0, "R9 ready when idle", int'(word_ready_o), 1);
    @(negedge clk);
    word_valid_i = 1'b0;
    chk(busy_o == 1'b1 && tx_o == 1'b1 && word_ready_o == 1'b0, "R9 busy after accept",
        int'({busy_o, tx_o, word_ready_o}), 6);
    for (int k = 0; k < n; k++) begin
      bit_tick_i = 1'b1;
      @(negedge clk);
      bit_tick_i = 1'b0;
      chk(tx_o == exp_bits[k], tag[k], int'(tx_o), int'(exp_bits[k]));
      if (midchg && k == 2) begin
        {len_hi_i, len_lo_i, stop_code_i} = 4'b1111;
        par_en_i = ~par_en_i;
        #0.5;
        chk(cfg_err_o == 1'b1, "R10 error follows fields", int'(cfg_err_o), 1);
      end
      if (k == 0) begin
        @(negedge clk);
        chk(tx_o == 1'b0 && busy_o == 1'b1, "R2 hold between ticks", int'(tx_o), 0);
      end
    end
    bit_tick_i = 1'b1;
    @(negedge clk);
    bit_tick_i = 1'b0;
    chk(busy_o == 1'b0 && tx_o == 1'b1, "R6 idle after frame", int'({busy_o, tx_o}), 1);
  endtask

  task automatic reject(input logic [5:0] f, input string req);
    @(negedge clk);
    {len_hi_i, len_lo_i, par_en_i, par_odd_i, stop_code_i} = f;
    word_i = 9'h0AA;
    word_valid_i = 1'b1;
    #0.5;
    chk(cfg_err_o == 1'b1 && word_ready_o == 1'b0, req, int'({cfg_err_o, word_ready_o}), 2);
    for (int t = 0; t < 3; t++) begin
      bit_tick_i = 1'b1;
      @(negedge clk);
      bit_tick_i = 1'b0;
      chk(busy_o == 1'b0 && tx_o == 1'b1, req, int'({busy_o, tx_o}), 1);
    end
    word_valid_i = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_o == 1'b1 && busy_o == 1'b0, "R1 reset line and busy", int'({tx_o, busy_o}), 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(word_ready_o == 1'b1 && cfg_err_o == 1'b0, "R1 ready after reset",
        int'({word_ready_o, cfg_err_o}), 2);
    for (int j = 0; j < 8; j++) send(VEC[j], 1'b0);
    reject(6'b110000, "R7 word length 11 rejected");
    reject(6'b000001, "R8 stop code 01 rejected");
    reject(6'b001011, "R8 stop code 11 rejected");
    send({1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 9'h0C6}, 1'b1);
    send({1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 9'h13C}, 1'b1);
    send({1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 9'h0F0}, 1'b0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule